// File: doc/BRIEF.md
# Full-Speed Root Port Controller

This block looks after the one downstream port of a full-speed host serial engine. It owns the D+ and D- pull-down resistor enables and samples the bus line state through a synchroniser and debounce filter. It runs the port through its sequences: bus reset, selective suspend and resume signalling. It also gates the start-of-frame (SOF) generator. Packet traffic, CRC and PID handling and the transceiver sit outside the block.

A register interface gives the block one-cycle command strobes and a status request strobe. The port status bits live here. There is a single port, with no overcurrent input and no power switch. The pull-downs are on from reset, so the bus idles in SE0. A bus reset first removes them, then drives SE0. That SE0 lasts until the next status request, not for a fixed time.

The controller is a state machine with six states:
- `PS_IDLE`: no enabled port.
- `PS_PDOFF`: one cycle in which the pull-downs are released.
- `PS_RESET`: SE0 is driven.
- `PS_ACTIVE`: the port is enabled.
- `PS_SUSP`: suspended, with SOF stopped.
- `PS_RESUME`: K is driven.

Its transitions:
- IDLE, ACTIVE or SUSP go to PDOFF on a reset command.
- PDOFF goes to RESET unconditionally.
- RESET goes to ACTIVE on a status request when connected, or to IDLE on a status request when not connected.
- ACTIVE goes to IDLE on a poll that finds no device.
- ACTIVE goes to SUSP on a suspend command.
- SUSP goes to RESUME on a resume command.
- RESUME goes to ACTIVE after `RESUME_CYC` cycles.

Top module: `icusb_root_port`

## Requirements
- R1: After reset, both pull-down enables are 1, `drive_se0`, `drive_k`, `sof_en`, `gsusp_ok` and `stat_valid` are 0, and a status request returns all status bits 0.
- R2: The line state is J when `line_state` is 2'b10 (bit 1 is D+, bit 0 is D-). It passes through two flops and must then hold for `DEBOUNCE` cycles. A poll command (code 6) while debounced J is present sets the connected bit and the connect-change bit. A poll after J has been present for only 3 cycles changes nothing.
- R3: A poll from idle or active with no debounced J, while connected, clears the connected and enabled bits, sets connect-change and returns the state machine to idle.
- R4: Command code 7 clears the connect-change bit. The other status bits are unchanged.
- R5: A reset command (code 1) clears both pull-down enables one cycle before `drive_se0` rises. The enables stay 0 afterwards.
- R6: `drive_se0` stays high until a status request. In the status returned for that request, the reset bit is already 0 and the enabled bit equals the connected bit.
- R7: A suspend command (code 2) in the active state sets the suspended bit, raises `gsusp_ok` and forces `sof_en` low.
- R8: A resume command (code 3) in the suspended state drives `drive_k` for exactly `RESUME_CYC` cycles. The port then returns to active with the suspended bit clear.
- R9: `sof_en` is high exactly when a start command (code 4) was given more recently than a stop command (code 5) and the port is active.
- R10: A command that does not apply in the current state is ignored. This covers suspend while idle, resume while not suspended, and poll during reset or suspend.
- R11: `stat_valid` pulses high in the cycle after `stat_req`. `stat_word` then holds bit 0 connected, bit 1 enabled, bit 2 suspended, bit 3 reset in progress and bit 4 connect-change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_state | input | 2 | Raw bus line, bit 1 D+, bit 0 D- |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| stat_req | input | 1 | Status request strobe |
| stat_valid | output | 1 | Status response valid |
| stat_word | output | 5 | Port status bits |
| pd_dp_en | output | 1 | D+ pull-down enable |
| pd_dm_en | output | 1 | D- pull-down enable |
| drive_se0 | output | 1 | Drive reset SE0 on the bus |
| drive_k | output | 1 | Drive resume K on the bus |
| sof_en | output | 1 | Allow SOF generation |
| gsusp_ok | output | 1 | Port quiet, global suspend allowed |

## Verification
Several properties are checked on every cycle:
- SE0 is never driven while a pull-down is on, and the pull-downs never come back.
- A status request during reset ends SE0 in the next cycle.
- The response strobe follows the request by one cycle.
- SOF is never enabled during suspend, reset or resume.
- The K drive never runs longer than `RESUME_CYC` cycles.

Other behaviours only show over the bench's command sequences, checked against a reference model:
- the debounce threshold;
- connect and disconnect reporting;
- clearing of the change bit;
- exact resume length;
- ignored commands.

// File: rtl/icusb_pkg.sv
package icusb_pkg;

    typedef enum logic [2:0] {
        PS_IDLE   = 3'd0,
        PS_PDOFF  = 3'd1,
        PS_RESET  = 3'd2,
        PS_ACTIVE = 3'd3,
        PS_SUSP   = 3'd4,
        PS_RESUME = 3'd5
    } port_state_e;

    localparam logic [2:0] CMD_BUSRST  = 3'd1;
    localparam logic [2:0] CMD_SUSPEND = 3'd2;
    localparam logic [2:0] CMD_RESUME  = 3'd3;
    localparam logic [2:0] CMD_SOF_ON  = 3'd4;
    localparam logic [2:0] CMD_SOF_OFF = 3'd5;
    localparam logic [2:0] CMD_POLL    = 3'd6;
    localparam logic [2:0] CMD_ACKCHG  = 3'd7;

    localparam logic [1:0] LINE_J = 2'b10;

    localparam int STW = 5;
    localparam int SB_CONN = 0;
    localparam int SB_EN   = 1;
    localparam int SB_SUSP = 2;
    localparam int SB_RST  = 3;
    localparam int SB_CHG  = 4;

endpackage

// File: rtl/icusb_line_sync.sv
module icusb_line_sync #(
    parameter int DEBOUNCE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_raw,
    output logic       j_stable
);
    import icusb_pkg::*;

    localparam int CW = $clog2(DEBOUNCE + 1);
    localparam logic [CW-1:0] CMAX = CW'(DEBOUNCE);

    logic [1:0]    meta_q;
    logic [1:0]    sync_q;
    logic [CW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 2'b00;
            sync_q <= 2'b00;
            hold_q <= '0;
        end else begin
            meta_q <= line_raw;
            sync_q <= meta_q;
            if (sync_q != LINE_J) begin
                hold_q <= '0;
            end else if (hold_q != CMAX) begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    assign j_stable = (hold_q == CMAX);

endmodule

// File: rtl/icusb_port_fsm.sv
module icusb_port_fsm #(
    parameter int RESUME_CYC = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     j_stable,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_code,
    input  logic                     stat_req,
    output logic [icusb_pkg::STW-1:0] status_nxt,
    output logic                     pd_en,
    output logic                     drive_se0,
    output logic                     drive_k,
    output logic                     sof_en,
    output logic                     gsusp_ok
);
    import icusb_pkg::*;

    localparam int RW = (RESUME_CYC > 1) ? $clog2(RESUME_CYC) : 1;
    localparam logic [RW-1:0] RLAST = RW'(RESUME_CYC - 1);

    port_state_e state_q, state_n;
    logic          conn_q, conn_n;
    logic          chg_q, chg_n;
    logic          pd_q;
    logic          sofreq_q;
    logic [RW-1:0] rcnt_q;

    function automatic logic is_cmd(input logic [2:0] c);
        return cmd_valid && (cmd_code == c);
    endfunction

    // next-state and connection bookkeeping
    always_comb begin
        state_n = state_q;
        conn_n  = conn_q;
        chg_n   = chg_q;
        if (is_cmd(CMD_ACKCHG)) begin
            chg_n = 1'b0;
        end
        unique case (state_q)
            PS_IDLE: begin
                if (is_cmd(CMD_BUSRST)) begin
                    state_n = PS_PDOFF;
                end else if (is_cmd(CMD_POLL)) begin
                    if (j_stable && !conn_q) begin
                        conn_n = 1'b1;
                        chg_n  = 1'b1;
                    end else if (!j_stable && conn_q) begin
                        conn_n = 1'b0;
                        chg_n  = 1'b1;
                    end
                end
            end
            PS_PDOFF: state_n = PS_RESET;
            PS_RESET: begin
                if (stat_req) begin
                    state_n = conn_q ? PS_ACTIVE : PS_IDLE;
                end
            end
            PS_ACTIVE: begin
                if (is_cmd(CMD_BUSRST)) begin
                    state_n = PS_PDOFF;
                end else if (is_cmd(CMD_SUSPEND)) begin
                    state_n = PS_SUSP;
                end else if (is_cmd(CMD_POLL)) begin
                    if (!j_stable) begin
                        conn_n  = 1'b0;
                        chg_n   = 1'b1;
                        state_n = PS_IDLE;
                    end
                end
            end
            PS_SUSP: begin
                if (is_cmd(CMD_BUSRST)) begin
                    state_n = PS_PDOFF;
                end else if (is_cmd(CMD_RESUME)) begin
                    state_n = PS_RESUME;
                end
            end
            PS_RESUME: begin
                if (rcnt_q == RLAST) begin
                    state_n = PS_ACTIVE;
                end
            end
            default: state_n = PS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            conn_q   <= 1'b0;
            chg_q    <= 1'b0;
            pd_q     <= 1'b1;
            sofreq_q <= 1'b0;
            rcnt_q   <= '0;
        end else begin
            state_q <= state_n;
            conn_q  <= conn_n;
            chg_q   <= chg_n;
            if (state_n == PS_PDOFF) begin
                pd_q <= 1'b0;
            end
            if (is_cmd(CMD_SOF_ON)) begin
                sofreq_q <= 1'b1;
            end else if (is_cmd(CMD_SOF_OFF)) begin
                sofreq_q <= 1'b0;
            end
            if (state_q == PS_RESUME) begin
                rcnt_q <= rcnt_q + 1'b1;
            end else begin
                rcnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        pd_en     = pd_q;
        drive_se0 = (state_q == PS_RESET);
        drive_k   = (state_q == PS_RESUME);
        sof_en    = sofreq_q && (state_q == PS_ACTIVE);
        gsusp_ok  = (state_q == PS_SUSP);
        status_nxt          = '0;
        status_nxt[SB_CONN] = conn_n;
        status_nxt[SB_EN]   = (state_n == PS_ACTIVE) || (state_n == PS_SUSP) ||
                              (state_n == PS_RESUME);
        status_nxt[SB_SUSP] = (state_n == PS_SUSP) || (state_n == PS_RESUME);
        status_nxt[SB_RST]  = (state_n == PS_PDOFF) || (state_n == PS_RESET);
        status_nxt[SB_CHG]  = chg_n;
    end

endmodule

// File: rtl/icusb_stat_resp.sv
module icusb_stat_resp #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stat_req,
    input  logic [W-1:0] status_nxt,
    output logic         stat_valid,
    output logic [W-1:0] stat_word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            stat_word  <= '0;
        end else begin
            stat_valid <= stat_req;
            if (stat_req) begin
                stat_word <= status_nxt;
            end
        end
    end
endmodule

// File: rtl/icusb_root_port.sv
module icusb_root_port #(
    parameter int DEBOUNCE   = 16,
    parameter int RESUME_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       stat_req,
    output logic       stat_valid,
    output logic [4:0] stat_word,
    output logic       pd_dp_en,
    output logic       pd_dm_en,
    output logic       drive_se0,
    output logic       drive_k,
    output logic       sof_en,
    output logic       gsusp_ok
);
    import icusb_pkg::*;

    logic           j_stable;
    logic           pd_en;
    logic [STW-1:0] status_nxt;

    icusb_line_sync #(.DEBOUNCE(DEBOUNCE)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (line_state),
        .j_stable (j_stable)
    );

    icusb_port_fsm #(.RESUME_CYC(RESUME_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .j_stable   (j_stable),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .stat_req   (stat_req),
        .status_nxt (status_nxt),
        .pd_en      (pd_en),
        .drive_se0  (drive_se0),
        .drive_k    (drive_k),
        .sof_en     (sof_en),
        .gsusp_ok   (gsusp_ok)
    );

    icusb_stat_resp #(.W(STW)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_req   (stat_req),
        .status_nxt (status_nxt),
        .stat_valid (stat_valid),
        .stat_word  (stat_word)
    );

    assign pd_dp_en = pd_en;
    assign pd_dm_en = pd_en;

endmodule

// File: rtl/icusb_root_port_chk.sv
module icusb_root_port_chk #(
    parameter int RESUME_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic stat_req,
    input logic stat_valid,
    input logic pd_dp_en,
    input logic pd_dm_en,
    input logic drive_se0,
    input logic drive_k,
    input logic sof_en,
    input logic gsusp_ok
);
    localparam int KW = $clog2(RESUME_CYC + 2);
    logic [KW-1:0] krun_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            krun_q <= '0;
        end else if (drive_k) begin
            if (krun_q != {KW{1'b1}}) krun_q <= krun_q + 1'b1;
        end else begin
            krun_q <= '0;
        end
    end

    AST_SE0_NO_PULLDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        drive_se0 |-> (!pd_dp_en && !pd_dm_en)); // R5
    AST_PD_RELEASED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_se0) |-> $past(!pd_dp_en && !pd_dm_en)); // R5
    AST_PD_NEVER_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_dp_en |=> !pd_dp_en); // R5
    AST_QUERY_ENDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_req && drive_se0) |=> !drive_se0); // R6
    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        stat_req |=> stat_valid); // R11
    AST_RESP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_req |=> !stat_valid); // R11
    AST_SOF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sof_en |-> (!gsusp_ok && !drive_se0 && !drive_k)); // R9
    AST_RESUME_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        drive_k |-> (krun_q < KW'(RESUME_CYC))); // R8
    AST_SINGLE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_se0 && drive_k)); // R8

endmodule

bind icusb_root_port icusb_root_port_chk #(.RESUME_CYC(RESUME_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_req   (stat_req),
    .stat_valid (stat_valid),
    .pd_dp_en   (pd_dp_en),
    .pd_dm_en   (pd_dm_en),
    .drive_se0  (drive_se0),
    .drive_k    (drive_k),
    .sof_en     (sof_en),
    .gsusp_ok   (gsusp_ok)
);

// File: tb/icusb_root_port_tb.sv
module icusb_root_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEB = 16;
    localparam int RCYC = 20;
    localparam logic [1:0] LJ = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_state = 2'b00;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       stat_req = 1'b0;
    logic       stat_valid;
    logic [4:0] stat_word;
    logic       pd_dp_en, pd_dm_en, drive_se0, drive_k, sof_en, gsusp_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    bit m_conn, m_en, m_susp, m_rst, m_chg, m_pd, m_sof, m_j;

    always #(CLK_PERIOD/2) clk = ~clk;

    icusb_root_port #(.DEBOUNCE(DEB), .RESUME_CYC(RCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_state(line_state),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .stat_req(stat_req),
        .stat_valid(stat_valid), .stat_word(stat_word),
        .pd_dp_en(pd_dp_en), .pd_dm_en(pd_dm_en), .drive_se0(drive_se0),
        .drive_k(drive_k), .sof_en(sof_en), .gsusp_ok(gsusp_ok)
    );

    function automatic logic [4:0] exp_word();
        return {m_chg, m_rst, m_susp, m_en, m_conn};
    endfunction

    function automatic logic exp_sof();
        return m_sof && m_en && !m_susp && !m_rst;
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic check_outs(input string rq);
        chk({rq, " pd_dp"}, pd_dp_en, m_pd);
        chk({rq, " pd_dm"}, pd_dm_en, m_pd);
        chk({rq, " se0"}, drive_se0, m_rst);
        chk({rq, " k"}, drive_k, 0);
        chk({rq, " R9 sof"}, sof_en, exp_sof());
        chk({rq, " R7 gsusp"}, gsusp_ok, m_susp);
    endtask

    task automatic set_line(input logic [1:0] v, input int wait_cyc);
        line_state = v;
        repeat (wait_cyc) @(negedge clk);
        m_j = (v == LJ) && (wait_cyc >= DEB + 3);
    endtask

    task automatic query(input string rq);
        stat_req = 1'b1;
        @(negedge clk);
        stat_req = 1'b0;
        if (m_rst) begin
            m_rst = 0;
            m_en  = m_conn;
        end
        chk({rq, " R11 valid"}, stat_valid, 1);
        chk({rq, " R11 word"}, stat_word, exp_word());
        chk({rq, " R6 se0 off"}, drive_se0, 0);
        @(negedge clk);
        chk({rq, " R11 drop"}, stat_valid, 0);
    endtask

    task automatic send(input logic [2:0] code, input string rq);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 3'd0;
        case (code)
            3'd1: if (!m_rst) begin
                chk({rq, " R5 pd off first"}, pd_dp_en, 0);
                chk({rq, " R5 no se0 yet"}, drive_se0, 0);
                @(negedge clk);
                m_pd = 0; m_rst = 1; m_en = 0; m_susp = 0;
            end
            3'd2: if (m_en && !m_susp && !m_rst) m_susp = 1;
            3'd3: if (m_susp) begin
                int kc = 0;
                while (drive_k && kc < 1000) begin
                    kc++;
                    @(negedge clk);
                end
                chk({rq, " R8 K length"}, kc, RCYC);
                m_susp = 0;
            end
            3'd4: m_sof = 1;
            3'd5: m_sof = 0;
            3'd6: if (!m_rst && !m_susp) begin
                if (m_j && !m_conn) begin m_conn = 1; m_chg = 1; end
                else if (!m_j && m_conn) begin m_conn = 0; m_chg = 1; m_en = 0; end
            end
            3'd7: m_chg = 0;
            default: ;
        endcase
        check_outs(rq);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'h5EED);
        m_conn = 0; m_en = 0; m_susp = 0; m_rst = 0; m_chg = 0;
        m_pd = 1; m_sof = 0; m_j = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_outs("R1");
        chk("R1 valid", stat_valid, 0);
        query("R1");

        // R10: suspend/resume while idle are ignored
        send(3'd2, "R10 suspend idle");
        send(3'd3, "R10 resume idle");
        query("R10 idle");

        // R2: short J not accepted
        set_line(LJ, 3);
        send(3'd6, "R2 short J");
        query("R2 short");
        // R2: debounced J
        set_line(LJ, DEB + 4);
        send(3'd6, "R2 poll");
        query("R2 connect");
        send(3'd7, "R4 ack");
        query("R4 cleared");

        // R5/R6: reset held until query
        send(3'd1, "R5 reset");
        repeat (30) @(negedge clk);
        chk("R6 still se0", drive_se0, 1);
        send(3'd6, "R10 poll during reset");
        query("R6 end reset");

        // R9/R7/R8
        send(3'd4, "R9 sof on");
        send(3'd2, "R7 suspend");
        send(3'd6, "R10 poll in suspend");
        send(3'd3, "R8 resume");
        query("R8 after resume");
        send(3'd5, "R9 sof off");

        // R3: disconnect
        set_line(2'b00, DEB + 4);
        send(3'd6, "R3 poll");
        query("R3 disconnect");

        // random phase
        for (int i = 0; i < 400; i++) begin
            r = $urandom_range(0, 9);
            if (r == 9) begin
                set_line(($urandom_range(0, 1) == 1) ? LJ : 2'b00, DEB + 4);
            end else if (r == 8) begin
                query("R11 rand");
            end else if (r == 0) begin
                send(3'd6, "R2 rand poll");
            end else begin
                send(3'(r), "R10 rand cmd");
            end
        end
        query("R11 final");
        done = 1;
        finish_run();
    end

endmodule